// File: doc/BRIEF.md
# Programmable Watchdog Countdown Timer

This block is a watchdog countdown timer behind a two-register window on a simple single-cycle bus. One register carries control and status bits; the other sets the timeout and returns the time left when read. Software programs a timeout and sets the run bit. While the timer runs, software keeps it alive with trigger writes, each of which reloads the counter from the timeout. A prescaler turns the clock into countdown steps. A configuration input picks a fine step or a coarse step, and the coarse step is the one-second setting. If the counter reaches zero, the block pulses a reset request or a power-off request for one clock and sets a sticky fired flag.

The fired flag is on a separate power-on reset. A system reset caused by the watchdog therefore leaves the flag set, and software can find out why the system restarted. A hardware-disabled input shows up as a read-only status bit and freezes the timer. A window-enable input gates all register access.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word (word address 0) reads 0 and the count word (word address 1) reads DEF_TIMEOUT (60). Both request outputs are low.
- R2: A write to word address 1 sets the timeout and loads the counter with it. Written value 0 becomes 1. Any value with a bit set in [31:16] saturates to 0xFFFF. Otherwise bits [15:0] are used. Reading word address 1 returns the current counter value, zero-extended.
- R3: Control bit 0 is the run bit. While it is set and the counter is non-zero, the counter falls by one every FAST_DIV clocks when resSel is 0, and every SLOW_DIV clocks when resSel is 1. The first step lands FAST_DIV (or SLOW_DIV) edges after the first edge at which the run bit is set.
- R4: Clearing the run bit halts the countdown. The counter value is held.
- R5: Control bit 1 is the trigger bit. A control write with bit 1 and bit 0 both set, made while the run bit is already set, reloads the counter from the timeout and restarts the prescaler. Bit 1 always reads 0.
- R6: A trigger has no effect on the counter in two cases: when it arrives in the same write that sets the run bit, and when the timer is stopped.
- R7: When the running counter steps from 1 to 0, exactly one output pulses high for one clock. The output is rstReq when action bit 2 is 0, and offReq when it is 1. The pulse is visible while the count reads 0. The counter then stays at 0 until a reload.
- R8: Control bit 4 is the fired flag. It is set on expiry, and a control write with bit 4 set clears it. It keeps its value through rst_n and is cleared only by por_n.
- R9: Control bit 3 reads hwDisabled. While hwDisabled is high, writes to the run bit and triggers are ignored and the counter does not step.
- R10: While decodeEn is low, bus writes change nothing and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low timer reset (everything except the fired flag) |
| por_n | input | 1 | Active-low power-on reset for the fired flag |
| decodeEn | input | 1 | Enables access to the register window |
| resSel | input | 1 | Step resolution: 0 = fine, 1 = coarse (one-second) |
| hwDisabled | input | 1 | Marks the watchdog hardware unusable |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address: 0 control, 1 count |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as busSel |
| rstReq | output | 1 | One-clock reset request on expiry |
| offReq | output | 1 | One-clock power-off request on expiry |

## Verification
Reads are combinational, so read data is sampled in the same low clock phase in which the read is driven. A write takes effect at the next rising edge and is visible in the following low phase. A countdown step shows up DIV edges after the last reload or after the run bit took effect. The request pulse appears in the low phase right after the edge that moved the counter from 1 to 0, and it is gone one phase later. The bench keeps a step-by-step reference updated on the same edges from the driven inputs, and compares outputs to it mid-way through the low phase. Directed sequences pin these latencies with literal values where they can be worked out by hand.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned TO_W = 16;

  // control word bit positions
  localparam int unsigned CtlRun   = 0;
  localparam int unsigned CtlTrig  = 1;
  localparam int unsigned CtlAct   = 2;
  localparam int unsigned CtlDis   = 3;
  localparam int unsigned CtlFired = 4;

  typedef struct packed {
    logic            load;
    logic [TO_W-1:0] loadVal;
    logic            runEn;
    logic            action;
    logic            clrFired;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DEF_TIMEOUT = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decodeEn,
  input  logic              hwDisabled,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [TO_W-1:0]   cnt,
  input  logic              fired,
  output wdStrobe_t         stb,
  output logic [31:0]       busRdata
);
  localparam logic [ADDR_W-1:0] AddrCtl = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AddrCnt = ADDR_W'(1);
  localparam logic [TO_W-1:0]   MaxTo   = {TO_W{1'b1}};

  logic            runQ, actQ;
  logic [TO_W-1:0] toQ;
  logic            wrAcc, rdAcc, ctlWr, cntWr, trigOk;
  logic [TO_W-1:0] wrVal;

  always_comb begin
    wrAcc  = busSel && busWr && decodeEn;
    rdAcc  = busSel && !busWr && decodeEn;
    ctlWr  = wrAcc && (busAddr == AddrCtl);
    cntWr  = wrAcc && (busAddr == AddrCnt);
    if (|busWdata[31:TO_W])              wrVal = MaxTo;
    else if (busWdata[TO_W-1:0] == '0)   wrVal = TO_W'(1);
    else                                 wrVal = busWdata[TO_W-1:0];
    trigOk = ctlWr && !hwDisabled && runQ && busWdata[CtlRun] && busWdata[CtlTrig];
    stb.load     = cntWr || trigOk;
    stb.loadVal  = cntWr ? wrVal : toQ;
    stb.runEn    = runQ && !hwDisabled;
    stb.action   = actQ;
    stb.clrFired = ctlWr && busWdata[CtlFired];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ <= 1'b0;
      actQ <= 1'b0;
      toQ  <= TO_W'(DEF_TIMEOUT);
    end else begin
      if (ctlWr) begin
        if (!hwDisabled) runQ <= busWdata[CtlRun];
        actQ <= busWdata[CtlAct];
      end
      if (cntWr) toQ <= wrVal;
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      if (busAddr == AddrCtl) begin
        busRdata[CtlRun]   = runQ;
        busRdata[CtlAct]   = actQ;
        busRdata[CtlDis]   = hwDisabled;
        busRdata[CtlFired] = fired;
      end else if (busAddr == AddrCnt) begin
        busRdata[TO_W-1:0] = cnt;
      end
    end
  end

  // R5: trigger bit never reads back as set
  p_trig_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busRdata[CtlTrig] == 1'b0);
  // R10: closed window returns zero
  p_closed_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !decodeEn |-> busRdata == 32'd0);
  // R9: run bit frozen while hardware disabled
  p_dis_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hwDisabled |=> runQ == $past(runQ));
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int unsigned FAST_DIV    = 1000,
  parameter int unsigned SLOW_DIV    = 100000000,
  parameter int unsigned DEF_TIMEOUT = 60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_n,
  input  logic            resSel,
  input  wdStrobe_t       stb,
  output logic [TO_W-1:0] cnt,
  output logic            fired,
  output logic            rstReq,
  output logic            offReq
);
  localparam int unsigned MaxDiv = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int unsigned PRE_W  = $clog2(MaxDiv + 1);

  logic [PRE_W-1:0] presc, lim;
  logic counting, tick, expire;

  always_comb begin
    lim      = resSel ? PRE_W'(SLOW_DIV - 1) : PRE_W'(FAST_DIV - 1);
    counting = stb.runEn && (cnt != '0) && !stb.load;
    tick     = counting && (presc >= lim);
    expire   = tick && (cnt == TO_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      cnt    <= TO_W'(DEF_TIMEOUT);
      rstReq <= 1'b0;
      offReq <= 1'b0;
    end else begin
      if (stb.load || tick) presc <= '0;
      else if (counting)    presc <= presc + 1'b1;
      if (stb.load)  cnt <= stb.loadVal;
      else if (tick) cnt <= cnt - 1'b1;
      rstReq <= expire && !stb.action;
      offReq <= expire && stb.action;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            fired <= 1'b0;
    else if (expire)       fired <= 1'b1;
    else if (stb.clrFired) fired <= 1'b0;
  end

  // R7: at most one request, one clock long, only at zero
  p_req_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rstReq, offReq}));
  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rstReq || offReq) |=> !(rstReq || offReq));
  p_req_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rstReq || offReq) |-> cnt == '0);
  p_zero_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !stb.load) |=> cnt == '0);
  // R8: fired flag set alongside any request
  p_fired_set_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rstReq || offReq) |-> fired);
  // R4: stopped counter is held
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.runEn && !stb.load) |=> $stable(cnt));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned FAST_DIV    = 1000,
  parameter int unsigned SLOW_DIV    = 100000000,
  parameter int unsigned DEF_TIMEOUT = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              decodeEn,
  input  logic              resSel,
  input  logic              hwDisabled,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rstReq,
  output logic              offReq
);
  wdStrobe_t       stb;
  logic [TO_W-1:0] cnt;
  logic            fired;

  wdog_ctl #(.ADDR_W(ADDR_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .decodeEn(decodeEn), .hwDisabled(hwDisabled),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .cnt(cnt), .fired(fired), .stb(stb), .busRdata(busRdata)
  );

  wdog_dp #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .DEF_TIMEOUT(DEF_TIMEOUT)) u_dp (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .resSel(resSel), .stb(stb),
    .cnt(cnt), .fired(fired), .rstReq(rstReq), .offReq(offReq)
  );
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int FD = 3;
  localparam int SD = 7;
  localparam int DT = 60;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, por_n, decodeEn, resSel, hwDis, busSel, busWr, rstReq, offReq;
  logic [1:0]  busAddr;
  logic [31:0] busWdata, busRdata;

  wdog_timer #(.ADDR_W(2), .FAST_DIV(FD), .SLOW_DIV(SD), .DEF_TIMEOUT(DT)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .decodeEn(decodeEn), .resSel(resSel),
    .hwDisabled(hwDis), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq), .offReq(offReq)
  );

  int total = 0, bad = 0, cyc = 0, rstSeen = 0, offSeen = 0;
  bit done = 0;
  bit mRun, mAct, mFired, mRst, mOff;
  int mTo, mCnt, mPre;

  function automatic int clampv(logic [31:0] d);
    if (|d[31:16]) return 65535;
    if (d[15:0] == 16'd0) return 1;
    return int'(d[15:0]);
  endfunction

  function automatic logic [31:0] expRead(logic [1:0] a);
    logic [31:0] r = 32'd0;
    if (!decodeEn) return r;
    if (a == 2'd0) r = {27'd0, mFired, hwDis, mAct, 1'b0, mRun};
    else if (a == 2'd1) r = 32'(mCnt);
    return r;
  endfunction

  // reference model, stepped on the same edges from the driven inputs
  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!rst_n || !por_n) begin
      if (!por_n) mFired = 0;
      if (!rst_n) begin
        mRun = 0; mAct = 0; mTo = DT; mCnt = DT; mPre = 0; mRst = 0; mOff = 0;
      end
    end else begin
      bit wrA, ctlWr, cntWr, trig, load, counting, tick, expire;
      int lv, lim;
      wrA      = busSel && busWr && decodeEn;
      ctlWr    = wrA && busAddr == 2'd0;
      cntWr    = wrA && busAddr == 2'd1;
      trig     = ctlWr && !hwDis && mRun && busWdata[0] && busWdata[1];
      load     = cntWr || trig;
      lv       = cntWr ? clampv(busWdata) : mTo;
      counting = mRun && !hwDis && mCnt != 0 && !load;
      lim      = resSel ? SD : FD;
      tick     = counting && mPre >= lim - 1;
      expire   = tick && mCnt == 1;
      mRst = expire && !mAct;
      mOff = expire && mAct;
      if (expire) mFired = 1;
      else if (ctlWr && busWdata[4]) mFired = 0;
      if (load || tick) mPre = 0; else if (counting) mPre = mPre + 1;
      if (load) mCnt = lv; else if (tick) mCnt = mCnt - 1;
      if (ctlWr) begin
        if (!hwDis) mRun = busWdata[0];
        mAct = busWdata[2];
      end
      if (cntWr) mTo = lv;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // request outputs against the model, every low phase
  always @(negedge clk) begin
    #3;
    if (rst_n && por_n && !done) begin
      check(rstReq == mRst && offReq == mOff, "R7 req", {30'd0, offReq, rstReq}, {30'd0, mOff, mRst});
      if (rstReq) rstSeen++;
      if (offReq) offSeen++;
    end
  end

  // call right after a falling edge
  task automatic rd(logic [1:0] a, string tag, output logic [31:0] v);
    busSel = 1; busWr = 0; busAddr = a;
    #1;
    v = busRdata;
    check(v == expRead(a), tag, v, expRead(a));
    busSel = 0;
    #1;
  endtask

  task automatic rdLit(logic [1:0] a, logic [31:0] exp, string tag);
    logic [31:0] v;
    rd(a, tag, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(bit withPor);
    @(negedge clk);
    rst_n = 0; if (withPor) por_n = 0;
    idle(2);
    rst_n = 1; por_n = 1;
    idle(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int r;
    void'($urandom(1234));
    rst_n = 0; por_n = 0; decodeEn = 1; resSel = 0; hwDis = 0;
    busSel = 0; busWr = 0; busAddr = 0; busWdata = 0;
    idle(3);
    rst_n = 1; por_n = 1;
    idle(1);
    // R1 reset state
    rdLit(2'd0, 32'd0, "R1 ctl");
    rdLit(2'd1, 32'd60, "R1 cnt");
    // R2 count write, clamp and saturation
    wr(2'd1, 32'd0);           rdLit(2'd1, 32'd1, "R2 zero");
    wr(2'd1, 32'h0001_0005);   rdLit(2'd1, 32'hFFFF, "R2 sat");
    wr(2'd1, 32'd5);           rdLit(2'd1, 32'd5, "R2 load");
    // R3 fine step rate
    wr(2'd0, 32'd1);
    idle(3);                   rdLit(2'd1, 32'd4, "R3 first");
    idle(3);                   rdLit(2'd1, 32'd3, "R3 second");
    // R3 coarse step rate
    wr(2'd1, 32'd20); resSel = 1;
    idle(SD);                  rdLit(2'd1, 32'd19, "R3 slow");
    resSel = 0;
    // R4 stop holds
    wr(2'd0, 32'd0);
    rd(2'd1, "R4 a", v);
    idle(20);
    rd(2'd1, "R4 b", v2);
    check(v == v2, "R4 hold", v2, v);
    // R5 trigger reload
    wr(2'd1, 32'd9); wr(2'd0, 32'd1);
    idle(7);
    wr(2'd0, 32'd3);           rdLit(2'd1, 32'd9, "R5 reload");
    rdLit(2'd0, 32'd1, "R5 trig reads 0");
    // R6 ignored triggers
    idle(5);
    wr(2'd0, 32'd0);
    rd(2'd1, "R6 stop", v);
    wr(2'd0, 32'd2);           rdLit(2'd1, v, "R6 stopped trig");
    rdLit(2'd0, 32'd0, "R6 run stays 0");
    wr(2'd0, 32'd3);           rdLit(2'd1, v, "R6 same write");
    // R7 expiry, reset action
    rstSeen = 0; offSeen = 0;
    wr(2'd1, 32'd2);
    idle(3 * FD);
    rdLit(2'd1, 32'd0, "R7 zero");
    check(rstSeen == 1 && offSeen == 0, "R7 rst pulse", rstSeen, 1);
    idle(10);                  rdLit(2'd1, 32'd0, "R7 hold");
    // R8 fired flag
    rdLit(2'd0, 32'h11, "R8 fired set");
    doReset(0);
    rdLit(2'd0, 32'h10, "R8 survives rst_n");
    wr(2'd0, 32'h10);          rdLit(2'd0, 32'h0, "R8 w1c");
    // R7 power-off action
    wr(2'd1, 32'd1); wr(2'd0, 32'd5);
    idle(2 * FD);
    check(offSeen == 1 && rstSeen == 1, "R7 off pulse", offSeen, 1);
    rdLit(2'd0, 32'h15, "R8 fired again");
    doReset(1);
    rdLit(2'd0, 32'h0, "R8 por clears");
    // R9 hardware disabled
    hwDis = 1;
    wr(2'd0, 32'd1);           rdLit(2'd0, 32'h8, "R9 run ignored");
    rd(2'd1, "R9 cnt", v);
    idle(10);                  rdLit(2'd1, v, "R9 frozen");
    hwDis = 0;
    // R10 closed window
    decodeEn = 0;
    wr(2'd1, 32'd7);           rdLit(2'd1, 32'd0, "R10 read zero");
    decodeEn = 1;              rdLit(2'd1, 32'd60, "R10 write ignored");
    // random mix against the model
    for (int i = 0; i < 20000; i++) begin
      r = $urandom_range(0, 99);
      if (r < 55) idle(1);
      else if (r < 65) wr(2'd1, ($urandom_range(0, 19) == 0) ? $urandom : 32'($urandom_range(0, 8)));
      else if (r < 78) wr(2'($urandom_range(0, 3)), 32'($urandom_range(0, 31)));
      else if (r < 94) begin
        @(negedge clk);
        rd(2'($urandom_range(0, 2)), "RND read", v);
      end else if (r < 96) hwDis = ($urandom_range(0, 3) == 0);
      else if (r < 98) resSel = $urandom_range(0, 1);
      else decodeEn = ($urandom_range(0, 4) != 0);
    end
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule